// File: doc/BRIEF.md
# Shared Interrupt Combiner with Re-Assert

This block merges several active-high, level-sensitive interrupt requests into a single line meant for a processor input that responds only to rising edges. Each request is first passed through a two-flop synchronizer. The synchronized requests are published unmasked on a status word, so the service routine can see every source that is active. The interrupt line itself is driven by the OR of the sources that are not masked.

A plain OR of level requests can lock up an edge-only input. If a second source becomes active while the first is being serviced, the line simply stays high and never produces another edge. To avoid this, the processor pulses a clear strobe at the end of each service pass. The clear forces the line low for a programmable number of clock cycles, from 1 to 15. The line then follows the masked OR again. If any unmasked source is still active at that point, the line rises and the processor sees a fresh edge.

A mask register, loaded through a write strobe, removes individual sources from the OR. It does not hide them from the status word. A clear that arrives while the line is already low restarts the low-time countdown.

Top module: `irq_merge`

## Requirements
- R1: During and right after reset, `irq_o` is 0, `status_o` is all zeros and every source is unmasked (mask register = 0).
- R2: `status_o[i]` equals `req_i[i]` delayed by two clock edges, regardless of the mask bit for that source.
- R3: When no low window is running, `irq_o` equals the OR of `status_o & ~mask` as it stood one edge earlier. A source asserted at the port therefore raises `irq_o` after three edges.
- R4: A source whose mask bit is 1 never drives `irq_o` high, even though it still shows in `status_o`.
- R5: A clock edge that samples `clr_i` = 1 drives `irq_o` to 0.
- R6: After a clear with `low_cycles_i` = L (1..15), `irq_o` stays 0 for exactly L cycles. In the next cycle it goes to 1 if any unmasked source is still active, which produces a new rising edge.
- R7: `low_cycles_i` = 0 is treated as 1, giving a single low cycle.
- R8: A clear that arrives while `irq_o` is already low, including during a running low window, restarts the full L-cycle countdown.
- R9: If no unmasked source is active when the low window ends, `irq_o` stays 0 and rises later, once a source arrives (per R3).
- R10: A clock edge that samples `mask_we_i` = 1 loads `mask_wdata_i` into the mask register. Bit i = 1 masks source i. The new mask is used for `irq_o` from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Asynchronous level requests, active high |
| clr_i | input | 1 | Service-complete strobe from the processor |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | N_SRC | New mask value; bit i = 1 masks source i |
| low_cycles_i | input | 4 | Minimum low time after a clear, in cycles (0 treated as 1) |
| irq_o | output | 1 | Combined interrupt line for an edge-triggered input |
| status_o | output | N_SRC | Synchronized, unmasked request levels |

## Verification
Two functions can land in the same cycle.

The first pair is a clear and a still-active request. The clear must win for the whole low window, and the request must re-raise the line on the exact cycle after the window ends. The bench holds a source active, pulses the clear, and then samples `irq_o` on every cycle, expecting exactly L lows followed by a high.

The second pair is a fresh clear and a countdown already running. The bench issues a second clear part-way through a window and expects the full L lows to be counted again from that second strobe.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int HOLD_W = 4;

    typedef struct packed {
        logic              line;
        logic [HOLD_W-1:0] left;
    } ctl_t;

    function automatic logic [HOLD_W-1:0] eff_low(input logic [HOLD_W-1:0] cfg);
        return (cfg == '0) ? HOLD_W'(1) : cfg;
    endfunction

endpackage

// File: rtl/irq_merge_sync.sv
module irq_merge_sync #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] req_s
);
    logic [N_SRC-1:0] stg1_q;
    logic [N_SRC-1:0] stg2_q;
    logic [1:0]       warm_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stg1_q[i] <= 1'b0;
                stg2_q[i] <= 1'b0;
            end else begin
                stg1_q[i] <= req[i];
                stg2_q[i] <= stg1_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assign req_s = stg2_q;

    // R2: two-edge latency from port to synchronized level
    p_sync_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (req_s == $past(req, 2)));
endmodule

// File: rtl/irq_merge_mask.sv
module irq_merge_mask #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] mask
);
    logic [N_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (we) mask_q <= wdata;
    end

    assign mask = mask_q;

    // R10: a write lands in the register at the next edge
    p_mask_load_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> (mask == $past(wdata)));
endmodule

// File: rtl/irq_merge_ctl.sv
module irq_merge_ctl
    import irq_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic [HOLD_W-1:0] low_cfg,
    output logic              line
);
    ctl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.line = 1'b0;
            st_d.left = eff_low(low_cfg);
        end else if (st_q.left > HOLD_W'(1)) begin
            st_d.line = 1'b0;
            st_d.left = st_q.left - HOLD_W'(1);
        end else if (st_q.left == HOLD_W'(1)) begin
            st_d.line = active;
            st_d.left = '0;
        end else begin
            st_d.line = active;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign line = st_q.line;

    // R5: a sampled clear pulls the line low
    p_clr_low_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !line);

    // R6: the line is held low while the window is running
    p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.left != '0) |-> !line);

    // R8: a clear always reloads a nonzero window
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.left != '0));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import irq_merge_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              clr_i,
    input  logic              mask_we_i,
    input  logic [N_SRC-1:0]  mask_wdata_i,
    input  logic [HOLD_W-1:0] low_cycles_i,
    output logic              irq_o,
    output logic [N_SRC-1:0]  status_o
);
    logic [N_SRC-1:0] req_s;
    logic [N_SRC-1:0] mask_q;
    logic             any_live;

    irq_merge_sync #(.N_SRC(N_SRC)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .req   (req_i),
        .req_s (req_s)
    );

    irq_merge_mask #(.N_SRC(N_SRC)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we_i),
        .wdata (mask_wdata_i),
        .mask  (mask_q)
    );

    assign any_live = |(req_s & ~mask_q);

    irq_merge_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_i),
        .active  (any_live),
        .low_cfg (low_cycles_i),
        .line    (irq_o)
    );

    assign status_o = req_s;

    // R3: a rising line always has an unmasked source behind it
    p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(any_live));

    // R4: with no unmasked source the line cannot go or stay high
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !any_live |=> !irq_o);
endmodule

// File: tb/irq_merge_test.sv
module irq_merge_test;
    localparam int N = 4;
    localparam int NV = 6;
    // each vector: {req, mask, expected irq}
    localparam logic [8:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 1'b0},
        {4'b0001, 4'b0000, 1'b1},
        {4'b1000, 4'b1000, 1'b0},
        {4'b1010, 4'b1000, 1'b1},
        {4'b0110, 4'b0110, 1'b0},
        {4'b1111, 4'b1110, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         clr = 1'b0;
    logic         mwe = 1'b0;
    logic [N-1:0] mwd = '0;
    logic [3:0]   lowc = 4'd1;
    logic         irq;
    logic [N-1:0] stat;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_merge #(.N_SRC(N)) uut (
        .clk(clk), .rst(rst), .req_i(req), .clr_i(clr),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .low_cycles_i(lowc),
        .irq_o(irq), .status_o(stat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic write_mask(input logic [N-1:0] m);
        mwd = m; mwe = 1'b1;
        @(negedge clk);
        mwe = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 status", stat, 0);
        req = 4'b0001;
        ticks(4);
        check("R1 unmasked after reset", irq, 1);
        req = 4'b0000;
        ticks(4);

        // R2 latency: request at port shows after two edges
        req = 4'b0100;
        @(negedge clk);
        check("R2 status after one edge", stat, 4'b0000);
        @(negedge clk);
        check("R2 status after two edges", stat, 4'b0100);
        // R3 line after three edges
        check("R3 line not yet", irq, 0);
        @(negedge clk);
        check("R3 line after three edges", irq, 1);
        req = 4'b0000;
        ticks(4);

        // Table walk: R4 masking, R10 mask write, R2 status unmasked
        for (int v = 0; v < NV; v++) begin
            write_mask(VEC[v][4:1]);
            req = VEC[v][8:5];
            ticks(4);
            check($sformatf("R4/R10 vec%0d irq", v), irq, VEC[v][0]);
            check($sformatf("R2 vec%0d status", v), stat, VEC[v][8:5]);
        end
        write_mask(4'b0000);
        req = 4'b0000;
        ticks(4);

        // R5/R6: clear with L=3 and a source still active
        lowc = 4'd3;
        req = 4'b0010;
        ticks(4);
        check("R6 precondition", irq, 1);
        pulse_clr();
        check("R5 low after clear", irq, 0);
        for (int k = 2; k <= 3; k++) begin
            @(negedge clk);
            check($sformatf("R6 low cycle %0d", k), irq, 0);
        end
        @(negedge clk);
        check("R6 re-assert after window", irq, 1);

        // R7: L=0 acts as one low cycle
        lowc = 4'd0;
        pulse_clr();
        check("R7 single low cycle", irq, 0);
        @(negedge clk);
        check("R7 re-assert", irq, 1);

        // R8: clear mid-window restarts the full count
        lowc = 4'd4;
        pulse_clr();
        ticks(2);
        check("R8 mid window low", irq, 0);
        pulse_clr();
        for (int k = 1; k <= 4; k++) begin
            check($sformatf("R8 restarted low %0d", k), irq, 0);
            if (k < 4) @(negedge clk);
        end
        @(negedge clk);
        check("R8 re-assert after restarted window", irq, 1);

        // R9: clear with nothing active, then a late source
        req = 4'b0000;
        lowc = 4'd2;
        ticks(3);
        pulse_clr();
        ticks(6);
        check("R9 stays low with no source", irq, 0);
        req = 4'b1000;
        ticks(2);
        check("R9 not yet high", irq, 0);
        @(negedge clk);
        check("R9 late source raises line", irq, 1);

        // R4: masking an active source drops the line
        write_mask(4'b1000);
        @(negedge clk);
        check("R4 masked active source", irq, 0);
        check("R4 masked still in status", stat, 4'b1000);

        // R1: reset in the middle clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after re-reset", irq, 0);
        check("R1 status after re-reset", stat, 0);
        ticks(3);
        check("R1 mask cleared by reset", irq, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule